// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Hub

This block holds, for up to four processors, one pending bit per processor for inter-processor interrupts and one pending bit per processor for interval-timer interrupts. Each pending bit drives its processor's interrupt line directly: the inter-processor bits drive the level-3 lines and the timer bits drive the level-2 lines. Software changes the state through a single-cycle register write port. A control register carries three packed 4-bit masks (request IPI, clear IPI, clear timer) that act together in one write. Three raw-vector registers clear IPIs, clear timer interrupts or request IPIs from a plain bit vector in the low bits of the write data.

A periodic tick input, produced elsewhere, marks every processor's timer interrupt pending. Redundant or malformed operations do no harm to the state. They are reported as one-cycle error pulses: a request for an IPI already pending, a clear of an IPI not pending, a control write that carries no recognised field, and a raw-vector write whose vector is zero. The read port is combinational and shows the pending vectors, with the requesting processor's identifier merged into the control register view.

Top module: `cpu_irq_hub`

## Requirements
- R1: While reset is held and at the first clock after its release, both pending vectors, all interrupt lines and all four error pulses are 0.
- R2: A write to register 0 (control) with a nonzero mask in data bits [15:12] sets the pending IPI bit of each selected processor, and `ipi_irq` shows it after the same clock edge.
- R3: An IPI request whose target bit is already pending, and is not cleared by the same write, leaves that bit set and raises `err_dup_req` for exactly one cycle.
- R4: Control data bits [11:8] clear the selected pending IPI bits and drop their lines. If a selected bit was not pending, `err_clr_idle` pulses for one cycle and the other bits are unaffected.
- R5: Control data bits [7:4] clear the selected pending timer bits. Bits that are already clear stay clear, and no error is raised.
- R6: All three control fields act in the same write. For a processor selected by both IPI clear and IPI request, the clear applies first and the request second, so the bit ends pending. The duplicate flag is not raised, and the idle-clear flag is raised only if the bit was not pending before.
- R7: A control write with only data bit 28 set (error acknowledge) changes nothing and raises no error. A control write with bits 28 and [15:4] all zero raises `err_bad_ctrl` for one cycle and changes nothing.
- R8: A high `tick` sets every processor's pending timer bit after that clock edge. When a timer clear arrives in the same cycle, the tick wins and every bit ends set.
- R9: The raw-vector registers use data bits [NCPU-1:0]. A write to register 1 clears pending IPIs, with the idle-clear flag as in R4. A write to register 2 clears pending timer bits. A write to register 3 requests IPIs, with the duplicate flag as in R3.
- R10: A write to register 1, 2 or 3 with a zero vector raises `err_zero_vec` for one cycle and changes nothing.
- R11: Reading is combinational. Register 0 returns the IPI pending bits in [11:8], the timer pending bits in [7:4] and `rd_cpu_id` in [1:0]. Register 1 returns the IPI pending vector in the low bits. Register 2 returns the timer pending vector in the low bits. Register 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Register selected by the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Register selected for the read |
| rd_cpu_id | input | 2 | Identifier of the processor issuing the read |
| rd_data | output | DATA_W | Read data, combinational |
| tick | input | 1 | Periodic timer tick, one cycle wide |
| ipi_irq | output | NCPU | Level-3 inter-processor interrupt line per processor |
| tmr_irq | output | NCPU | Level-2 timer interrupt line per processor |
| err_dup_req | output | 1 | Pulse: IPI requested for an already pending processor |
| err_clr_idle | output | 1 | Pulse: IPI clear for a processor with none pending |
| err_bad_ctrl | output | 1 | Pulse: control write with no recognised field |
| err_zero_vec | output | 1 | Pulse: raw-vector write with an all-zero vector |

## Verification
The bench drives the same processor's bit through clear and request in one control write, both when the bit was pending and when it was not. A design that applied the request before the clear would lose the IPI, or would flag a spurious duplicate. A tick that coincides with a timer clear is also tested: a design that let the clear win would leave lines low that should be high. The bench tests control writes holding only the acknowledge bit, and others holding only bits outside every field, to tell an ignored write from an unsupported one. It also tests raw writes with zero vectors and repeated requests and clears, to show that each error pulse fires for its cause alone and lasts exactly one cycle.

// File: rtl/cpu_irq_hub_pkg.sv
package cpu_irq_hub_pkg;

   // register selectors on the write and read ports
   typedef enum logic [1:0] {
      SEL_CTRL    = 2'd0,
      SEL_IPI_CLR = 2'd1,
      SEL_TMR_CLR = 2'd2,
      SEL_IPI_SET = 2'd3
   } reg_sel_e;

   // packed field layout of the control register
   localparam int unsigned FLD_W        = 4;
   localparam int unsigned FLD_REQ_LSB  = 12;
   localparam int unsigned FLD_ICLR_LSB = 8;
   localparam int unsigned FLD_TCLR_LSB = 4;
   localparam int unsigned ACK_BIT      = 28;
   localparam int unsigned CPU_ID_W     = 2;
   localparam int unsigned MAX_CPU      = 4;

endpackage

// File: rtl/cpu_irq_hub_decode.sv
module cpu_irq_hub_decode
   import cpu_irq_hub_pkg::*;
#(
   parameter int unsigned NCPU   = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [NCPU-1:0]   ipi_set,
   output logic [NCPU-1:0]   ipi_clr,
   output logic [NCPU-1:0]   tmr_clr,
   output logic              bad_ctrl,
   output logic              zero_vec
);

   logic [FLD_W-1:0] req_f, iclr_f, tclr_f;
   logic             ack_f;
   logic [NCPU-1:0]  raw_v;
   logic             hit_ctrl, hit_iclr, hit_tclr, hit_iset, ctrl_ok;

   assign req_f  = wr_data[FLD_REQ_LSB  +: FLD_W];
   assign iclr_f = wr_data[FLD_ICLR_LSB +: FLD_W];
   assign tclr_f = wr_data[FLD_TCLR_LSB +: FLD_W];
   assign ack_f  = wr_data[ACK_BIT];
   assign raw_v  = wr_data[NCPU-1:0];

   assign hit_ctrl = wr_en && (wr_addr == ADDR_W'(SEL_CTRL));
   assign hit_iclr = wr_en && (wr_addr == ADDR_W'(SEL_IPI_CLR));
   assign hit_tclr = wr_en && (wr_addr == ADDR_W'(SEL_TMR_CLR));
   assign hit_iset = wr_en && (wr_addr == ADDR_W'(SEL_IPI_SET));

   assign ctrl_ok = (req_f != '0) || (iclr_f != '0) || (tclr_f != '0) || ack_f;

   always_comb begin
      ipi_set = '0;
      ipi_clr = '0;
      tmr_clr = '0;
      if (hit_ctrl) begin
         ipi_set = req_f[NCPU-1:0];
         ipi_clr = iclr_f[NCPU-1:0];
         tmr_clr = tclr_f[NCPU-1:0];
      end
      if (hit_iclr) ipi_clr = raw_v;
      if (hit_tclr) tmr_clr = raw_v;
      if (hit_iset) ipi_set = raw_v;
   end

   assign bad_ctrl = hit_ctrl && !ctrl_ok;
   assign zero_vec = (hit_iclr || hit_tclr || hit_iset) && (raw_v == '0);

   logic unused_bits;
   assign unused_bits = ^{wr_data[DATA_W-1:ACK_BIT+1],
                          wr_data[ACK_BIT-1:FLD_REQ_LSB+FLD_W]};

endmodule

// File: rtl/cpu_irq_hub_bank.sv
module cpu_irq_hub_bank #(
   parameter int unsigned NCPU    = 4,
   parameter bit          FLAG_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NCPU-1:0] set_v,
   input  logic [NCPU-1:0] clr_v,
   output logic [NCPU-1:0] pend,
   output logic            dup_o,
   output logic            idle_o
);

   // per-processor pending bit: clear first, then set
   for (genvar i = 0; i < NCPU; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  pend[i] <= 1'b0;
         else if (set_v[i])           pend[i] <= 1'b1;
         else if (clr_v[i])           pend[i] <= 1'b0;
      end
   end

   if (FLAG_EN) begin : g_flags
      logic [NCPU-1:0] dup_v, idle_v;
      assign dup_v  = set_v & pend & ~clr_v;
      assign idle_v = clr_v & ~pend;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dup_o  <= 1'b0;
            idle_o <= 1'b0;
         end else begin
            dup_o  <= |dup_v;
            idle_o <= |idle_v;
         end
      end

      p_dup_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
         dup_o |-> $past((set_v & pend & ~clr_v) != '0));
      p_idle_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
         idle_o |-> $past((clr_v & ~pend) != '0));
   end else begin : g_noflags
      assign dup_o  = 1'b0;
      assign idle_o = 1'b0;
   end

   p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (set_v == '0) |=> ((pend & ~$past(pend)) == '0));
   p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_v & ~set_v) != '0) |=> ((pend & $past(clr_v & ~set_v)) == '0));

endmodule

// File: rtl/cpu_irq_hub_rdmux.sv
module cpu_irq_hub_rdmux
   import cpu_irq_hub_pkg::*;
#(
   parameter int unsigned NCPU   = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 2
) (
   input  logic [ADDR_W-1:0]   rd_addr,
   input  logic [CPU_ID_W-1:0] rd_cpu_id,
   input  logic [NCPU-1:0]     ipi,
   input  logic [NCPU-1:0]     tmr,
   output logic [DATA_W-1:0]   rd_data
);

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         ADDR_W'(SEL_CTRL): begin
            rd_data[FLD_ICLR_LSB +: NCPU] = ipi;
            rd_data[FLD_TCLR_LSB +: NCPU] = tmr;
            rd_data[CPU_ID_W-1:0]         = rd_cpu_id;
         end
         ADDR_W'(SEL_IPI_CLR): rd_data[NCPU-1:0] = ipi;
         ADDR_W'(SEL_TMR_CLR): rd_data[NCPU-1:0] = tmr;
         default:              rd_data = '0;
      endcase
   end

endmodule

// File: rtl/cpu_irq_hub.sv
module cpu_irq_hub
   import cpu_irq_hub_pkg::*;
#(
   parameter int unsigned NCPU   = 4,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [1:0]        rd_cpu_id,
   output logic [DATA_W-1:0] rd_data,
   input  logic              tick,
   output logic [NCPU-1:0]   ipi_irq,
   output logic [NCPU-1:0]   tmr_irq,
   output logic              err_dup_req,
   output logic              err_clr_idle,
   output logic              err_bad_ctrl,
   output logic              err_zero_vec
);

   if (NCPU < 1 || NCPU > MAX_CPU) begin : g_bad_ncpu
      $error("cpu_irq_hub: NCPU must be 1..4");
   end
   if (DATA_W < 32) begin : g_bad_dw
      $error("cpu_irq_hub: DATA_W must be at least 32");
   end
   if (ADDR_W < 2) begin : g_bad_aw
      $error("cpu_irq_hub: ADDR_W must be at least 2");
   end

   logic [NCPU-1:0] ipi_set, ipi_clr, tmr_clr, tmr_set;
   logic            bad_c, zero_c;
   logic            unused_tmr_dup, unused_tmr_idle;

   cpu_irq_hub_decode #(.NCPU(NCPU), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .ipi_set (ipi_set),
      .ipi_clr (ipi_clr),
      .tmr_clr (tmr_clr),
      .bad_ctrl(bad_c),
      .zero_vec(zero_c)
   );

   cpu_irq_hub_bank #(.NCPU(NCPU), .FLAG_EN(1'b1)) u_ipi (
      .clk   (clk),
      .rst_n (rst_n),
      .set_v (ipi_set),
      .clr_v (ipi_clr),
      .pend  (ipi_irq),
      .dup_o (err_dup_req),
      .idle_o(err_clr_idle)
   );

   assign tmr_set = {NCPU{tick}};

   cpu_irq_hub_bank #(.NCPU(NCPU), .FLAG_EN(1'b0)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .set_v (tmr_set),
      .clr_v (tmr_clr),
      .pend  (tmr_irq),
      .dup_o (unused_tmr_dup),
      .idle_o(unused_tmr_idle)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_bad_ctrl <= 1'b0;
         err_zero_vec <= 1'b0;
      end else begin
         err_bad_ctrl <= bad_c;
         err_zero_vec <= zero_c;
      end
   end

   cpu_irq_hub_rdmux #(.NCPU(NCPU), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
      .rd_addr  (rd_addr),
      .rd_cpu_id(rd_cpu_id),
      .ipi      (ipi_irq),
      .tmr      (tmr_irq),
      .rd_data  (rd_data)
   );

   p_bad_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_bad_ctrl |-> $past(wr_en && wr_addr == ADDR_W'(SEL_CTRL)));
   p_zero_vec_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_zero_vec |-> $past(wr_en && wr_addr != ADDR_W'(SEL_CTRL)
                             && wr_data[NCPU-1:0] == '0));
   p_tick_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (&tmr_irq));
   p_zero_vec_keeps_ipi_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != ADDR_W'(SEL_CTRL) && wr_data[NCPU-1:0] == '0)
      |=> $stable(ipi_irq));

endmodule

// File: tb/cpu_irq_hub_bench.sv
`timescale 1ns/1ps
module cpu_irq_hub_bench;

   localparam int NCPU = 4;
   localparam int DW   = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [1:0]    rd_addr = '0;
   logic [1:0]    rd_cpu_id = 2'd2;
   logic [DW-1:0] rd_data;
   logic          tick = 1'b0;
   logic [3:0]    ipi_irq, tmr_irq;
   logic          err_dup_req, err_clr_idle, err_bad_ctrl, err_zero_vec;

   cpu_irq_hub #(.NCPU(NCPU), .DATA_W(DW), .ADDR_W(2)) u_cpu_irq_hub (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_cpu_id(rd_cpu_id), .rd_data(rd_data), .tick(tick),
      .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .err_dup_req(err_dup_req),
      .err_clr_idle(err_clr_idle), .err_bad_ctrl(err_bad_ctrl), .err_zero_vec(err_zero_vec)
   );

   always #10 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int         due;
      logic [3:0] ipi;
      logic [3:0] tmr;
      logic [3:0] flags;
      string      rq;
   } exp_t;
   exp_t q[$];

   logic [3:0] m_ipi = '0, m_tmr = '0;

   task automatic chk(input bit ok, input string rq, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", rq, got, exp);
      end
   endtask

   // driver: models the expected state and queues it for the monitor
   task automatic op(input logic we, input logic [1:0] a, input logic [31:0] d,
                     input logic tk, input string rq);
      logic [3:0] req, ic, tc, v, after;
      logic dup, idl, bad, zro;
      exp_t e;
      dup = 0; idl = 0; bad = 0; zro = 0;
      req = d[15:12]; ic = d[11:8]; tc = d[7:4]; v = d[3:0];
      if (we) begin
         if (a == 2'd0) begin
            bad = !(|req || |ic || |tc || d[28]);
            idl = |(ic & ~m_ipi);
            after = m_ipi & ~ic;
            dup = |(req & after);
            m_ipi = after | req;
            m_tmr = m_tmr & ~tc;
         end else begin
            zro = (v == 4'd0);
            if (a == 2'd1) begin idl = |(v & ~m_ipi); m_ipi = m_ipi & ~v; end
            if (a == 2'd2) m_tmr = m_tmr & ~v;
            if (a == 2'd3) begin dup = |(v & m_ipi); m_ipi = m_ipi | v; end
         end
      end
      if (tk) m_tmr = 4'hF;
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d; tick = tk;
      e.due = cyc + 1; e.ipi = m_ipi; e.tmr = m_tmr;
      e.flags = {dup, idl, bad, zro}; e.rq = rq;
      q.push_back(e);
   endtask

   task automatic nop(input string rq);
      op(1'b0, 2'd0, 32'd0, 1'b0, rq);
   endtask

   // monitor: compares outputs with queued expectations when due
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].due == cyc) begin
         exp_t e;
         logic [31:0] got, exp;
         e = q.pop_front();
         got = {4'd0, ipi_irq, tmr_irq, err_dup_req, err_clr_idle, err_bad_ctrl, err_zero_vec,
                rd_data[15:0]};
         exp = {4'd0, e.ipi, e.tmr, e.flags,
                4'd0, e.ipi, e.tmr, 4'd2};
         chk(got == exp, e.rq, got, exp);
      end
   end

   task automatic read_chk(input logic [1:0] a, input logic [1:0] id,
                           input logic [31:0] exp, input string rq);
      @(negedge clk);
      wr_en = 0; tick = 0;
      #2 rd_addr = a; rd_cpu_id = id;
      #2 chk(rd_data == exp, rq, rd_data, exp);
      rd_addr = 2'd0; rd_cpu_id = 2'd2;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk({ipi_irq, tmr_irq, err_dup_req, err_clr_idle, err_bad_ctrl, err_zero_vec} == 12'd0,
          "R1 reset held", {20'd0, ipi_irq, tmr_irq, err_dup_req, err_clr_idle,
          err_bad_ctrl, err_zero_vec}, 32'd0);
      rst_n = 1'b1;
      nop("R1 after release");
      op(1, 0, 32'h0000_5000, 0, "R2 request 0101");
      op(1, 0, 32'h0000_4000, 0, "R3 duplicate request");
      nop("R3 flag one cycle");
      op(1, 0, 32'h0000_0300, 0, "R4 clear with idle bit");
      nop("R4 flag one cycle");
      op(0, 0, 32'h0, 1, "R8 tick");
      op(1, 0, 32'h0000_0090, 0, "R5 timer clear");
      op(1, 0, 32'h0000_0090, 0, "R5 timer clear repeated");
      op(1, 0, 32'h0000_4400, 0, "R6 clear+request pending bit");
      op(1, 0, 32'h0000_2200, 0, "R6 clear+request idle bit");
      op(1, 0, 32'h0000_1820, 0, "R6 three fields at once");
      op(1, 0, 32'h1000_0000, 0, "R7 acknowledge only");
      op(1, 0, 32'h0000_0000, 0, "R7 empty control");
      op(1, 0, 32'h0000_000F, 0, "R7 bits outside fields");
      nop("R7 flag one cycle");
      op(1, 0, 32'h0000_00F0, 1, "R8 tick with timer clear");
      op(1, 3, 32'h0000_0004, 0, "R9 raw request");
      op(1, 3, 32'h0000_0004, 0, "R9 raw duplicate request");
      op(1, 1, 32'h0000_0003, 0, "R9 raw IPI clear");
      op(1, 2, 32'h0000_0005, 0, "R9 raw timer clear");
      op(1, 1, 32'h0000_0000, 0, "R10 zero IPI clear");
      op(1, 2, 32'h0000_0000, 0, "R10 zero timer clear");
      op(1, 3, 32'h0000_00F0, 0, "R10 zero request vector");
      nop("R10 flag one cycle");
      nop("R11 settle");
      read_chk(2'd0, 2'd1, {16'd0, 4'd0, m_ipi, m_tmr, 4'd1}, "R11 control view");
      read_chk(2'd1, 2'd3, {28'd0, m_ipi}, "R11 IPI vector");
      read_chk(2'd2, 2'd0, {28'd0, m_tmr}, "R11 timer vector");
      read_chk(2'd3, 2'd2, 32'd0, "R11 request register");
      op(1, 0, 32'h0000_0F00, 0, "R4 clear all");
      op(1, 2, 32'h0000_000F, 0, "R9 clear all timers");
      nop("R4 final");
      repeat (3) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule